// File: doc/BRIEF.md
# Serial Audio Input Deserializer

This block receives a serial audio stream made of a bit clock, a frame clock and one data line, and turns it into parallel samples, one word per channel. All three serial lines are brought into the system clock domain by synchronizers, and the sampling edge of the bit clock is found there. The system clock must therefore run at least four times faster than the bit clock. One receiver handles three stereo formats and four time-division-multiplexed (TDM) formats. A small set of configuration pins chooses the format, the word length, the bit-clock sampling edge and the frame-clock edge that opens a frame.

Each recovered channel comes out as a sign-extended word together with its channel number and a one-cycle valid strobe. A serial stream cannot be paused, so there is no ready input and no back-pressure. The consumer must take the word in the cycle the strobe is high. The word and the channel number then stay unchanged until the next strobe. After reset, and after any change on the configuration pins, the block stays silent until it sees the frame-clock edge that opens a frame.

The sampling edge and frame polarity pins take precedence over the format field. The format field only sets the MSB delay, the justification, the slot count and the frame-clock style. The frame-clock level that marks the first channel, and the bit-clock edge used for sampling, come only from the two polarity pins. Software should therefore write all configuration pins together.

Top module: `sai_rx`

## Requirements
- R1: With `cfg_mode` = 0 (7 behaves the same), the first channel's word starts one bit clock after the frame-opening edge and the second channel's word starts one bit clock after the opposite frame-clock edge. The MSB comes first. Channel 0 is the first half and channel 1 the second half.
- R2: With `cfg_mode` = 1, the MSB of each channel is the bit sampled together with the frame-clock transition, with no delay.
- R3: With `cfg_mode` = 2, the LSB of a channel is the last bit sampled before the frame-clock transition that ends it. The word is delivered at that transition.
- R4: In the stereo formats, `cfg_wlen` sets the word length: 0 gives 16 bits, 1 gives 20 bits, 2 or 3 give 24 bits. A shorter word is sign-extended to 24 bits on `out_data`. Bits outside the word are ignored.
- R5: With `cfg_bclk_edge` = 0, data is sampled on the rising bit-clock edge (data changes on the falling edge). With `cfg_bclk_edge` = 1, data is sampled on the falling edge.
- R6: With `cfg_fclk_pol` = 0, a frame opens on a falling frame-clock edge and the first channel is carried while the frame clock is low. With `cfg_fclk_pol` = 1, a frame opens on a rising edge and the first channel is carried while it is high.
- R7: `cfg_mode` = 3 selects 8-channel TDM and 4 selects 16-channel TDM, both with a 50% duty frame clock. Slots are 32 bit clocks wide and each slot's MSB is delayed by one bit clock. The first 24 bits of a slot form the word, taken MSB first. The first half-frame carries channels 0 to N/2-1 and the second half carries N/2 to N-1.
- R8: `cfg_mode` = 5 selects 8-channel TDM and 6 selects 16-channel TDM, both with a pulse frame clock. Only the frame-opening edge counts and the other edge is ignored. Channels 0 to N-1 follow one another across the whole frame in 32-bit slots, each with a one bit-clock MSB delay.
- R9: `out_valid` is high for exactly one cycle for each delivered channel, and channels are delivered in order. `out_chan` and `out_data` hold their values between strobes. After reset all three outputs are 0.
- R10: No word is delivered after reset, or after any change of a configuration pin, until a frame-opening edge has been sampled. In right-justified mode, the channel that ends at that first edge is also dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock (asynchronous) |
| fclk | input | 1 | Frame clock (asynchronous) |
| sdata | input | 1 | Serial data line |
| cfg_mode | input | 3 | Format select (see R1, R2, R3, R7, R8) |
| cfg_bclk_edge | input | 1 | Bit-clock sampling edge select (R5) |
| cfg_fclk_pol | input | 1 | Frame-opening edge select (R6) |
| cfg_wlen | input | 2 | Stereo word length (R4) |
| out_valid | output | 1 | One-cycle strobe per delivered channel |
| out_chan | output | 4 | Channel number of the delivered word |
| out_data | output | 24 | Sign-extended sample word |

## Verification
Each format is driven with frames of pseudo-random words whose unused padding bits are set to one. A wrong MSB delay, slot width or justification therefore shows up as corrupted words rather than passing unnoticed. The 16-bit cases use words with random sign bits, so they separate proper sign extension from zero fill. The two TDM duty styles are told apart by the channel numbers expected in the second half-frame, and by whether the pulse's trailing edge restarts counting. Every stream starts with an idle stretch of all-one data at the second-channel level, and one stream does nothing but toggle the frame clock after a format change. Any word delivered before a frame-opening edge is therefore caught as unexpected.

// File: rtl/sai_rx_pkg.sv
package sai_rx_pkg;

  typedef enum logic [2:0] {
    FMT_I2S    = 3'd0,
    FMT_LJ     = 3'd1,
    FMT_RJ     = 3'd2,
    FMT_TDM8   = 3'd3,
    FMT_TDM16  = 3'd4,
    FMT_TDM8P  = 3'd5,
    FMT_TDM16P = 3'd6,
    FMT_RSVD   = 3'd7
  } fmt_e;

  typedef struct packed {
    logic delayed;     // MSB one bit clock after the boundary
    logic right_just;  // LSB just before the boundary
    logic tdm;         // multichannel slots
    logic pulse;       // only the opening edge of the frame clock counts
    logic wide;        // full channel count instead of half
  } fmt_info_t;

  function automatic fmt_info_t fmt_decode(input logic [2:0] m);
    fmt_info_t r;
    r = '0;
    case (fmt_e'(m))
      FMT_LJ:     r = '0;
      FMT_RJ:     r.right_just = 1'b1;
      FMT_TDM8:   begin r.tdm = 1'b1; r.delayed = 1'b1; end
      FMT_TDM16:  begin r.tdm = 1'b1; r.delayed = 1'b1; r.wide = 1'b1; end
      FMT_TDM8P:  begin r.tdm = 1'b1; r.delayed = 1'b1; r.pulse = 1'b1; end
      FMT_TDM16P: begin r.tdm = 1'b1; r.delayed = 1'b1; r.pulse = 1'b1; r.wide = 1'b1; end
      default:    r.delayed = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sai_rx_sync.sv
module sai_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fclk,
  input  logic sdata,
  input  logic sample_lvl,
  output logic tick,
  output logic f_s,
  output logic d_s
);
  logic [STAGES-1:0] b_sh, f_sh, d_sh;
  logic              b_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_sh   <= '0;
      f_sh   <= '0;
      d_sh   <= '0;
      b_last <= 1'b0;
    end else begin
      b_sh   <= {b_sh[STAGES-2:0], bclk};
      f_sh   <= {f_sh[STAGES-2:0], fclk};
      d_sh   <= {d_sh[STAGES-2:0], sdata};
      b_last <= b_sh[STAGES-1];
    end
  end

  // a sampling edge: the synchronized bit clock just moved to the sampling level
  assign tick = (b_sh[STAGES-1] != b_last) && (b_sh[STAGES-1] == sample_lvl);
  assign f_s  = f_sh[STAGES-1];
  assign d_s  = d_sh[STAGES-1];
endmodule

// File: rtl/sai_rx_framer.sv
module sai_rx_framer #(
  parameter int POS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             f_s,
  input  logic             start_lvl,
  input  logic             pulse,
  input  logic             cfg_chg,
  output logic             boundary,
  output logic [POS_W-1:0] pos_cur,
  output logic             half_cur,
  output logic             half_prev,
  output logic             synced
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic             f_q, half_q, synced_q;
  logic [POS_W-1:0] pos_q;
  logic             edge_any, start_e, other_e;

  assign edge_any = tick && (f_s != f_q);
  assign start_e  = edge_any && (f_s == start_lvl);
  assign other_e  = edge_any && (f_s != start_lvl) && !pulse;
  assign boundary = start_e || other_e;

  assign pos_cur  = boundary ? '0 : ((pos_q == POS_MAX) ? pos_q : pos_q + 1'b1);
  assign half_cur = start_e ? 1'b0 : (other_e ? 1'b1 : half_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q      <= 1'b0;
      half_q   <= 1'b0;
      pos_q    <= '0;
      synced_q <= 1'b0;
    end else begin
      if (tick) begin
        f_q    <= f_s;
        pos_q  <= pos_cur;
        half_q <= half_cur;
      end
      if (cfg_chg)      synced_q <= 1'b0;
      else if (start_e) synced_q <= 1'b1;
    end
  end

  assign half_prev = half_q;
  assign synced    = synced_q;
endmodule

// File: rtl/sai_rx_assemble.sv
module sai_rx_assemble
  import sai_rx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_BITS = 32,
  parameter int MAX_CH    = 16,
  parameter int POS_W     = 10,
  parameter int CH_W      = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                d_s,
  input  fmt_info_t           info,
  input  logic [1:0]          wlen,
  input  logic                boundary,
  input  logic [POS_W-1:0]    pos_cur,
  input  logic                half_cur,
  input  logic                half_prev,
  input  logic                synced,
  input  logic                cfg_chg,
  output logic                out_valid,
  output logic [CH_W-1:0]     out_chan,
  output logic [SAMPLE_W-1:0] out_data
);
  localparam int SLOT_LG = $clog2(SLOT_BITS);
  localparam int SW      = POS_W - SLOT_LG;
  localparam int WL_W    = $clog2(SAMPLE_W + 1);

  logic [SAMPLE_W-1:0] sreg, sreg_nxt, src, word;
  logic [WL_W-1:0]     wl, used;
  logic [POS_W-1:0]    e;
  logic                e_ok, emit_tdm, emit_lj, emit_rj, emit;
  logic [SW-1:0]       slot, lim;
  logic [SLOT_LG-1:0]  bitpos;
  logic [CH_W-1:0]     chan;

  assign sreg_nxt = {sreg[SAMPLE_W-2:0], d_s};

  always_comb begin
    case (wlen)
      2'd0:    wl = WL_W'(SAMPLE_W - 8);
      2'd1:    wl = WL_W'(SAMPLE_W - 4);
      default: wl = WL_W'(SAMPLE_W);
    endcase
  end

  assign e_ok   = pos_cur >= POS_W'(info.delayed);
  assign e      = pos_cur - POS_W'(info.delayed);
  assign slot   = e[POS_W-1:SLOT_LG];
  assign bitpos = e[SLOT_LG-1:0];
  assign lim    = info.pulse ? (info.wide ? SW'(MAX_CH) : SW'(MAX_CH / 2))
                             : (info.wide ? SW'(MAX_CH / 2) : SW'(MAX_CH / 4));

  assign emit_tdm = info.tdm && e_ok && (bitpos == SLOT_LG'(SAMPLE_W - 1)) && (slot < lim);
  assign emit_lj  = !info.tdm && !info.right_just && e_ok && (e == POS_W'(wl) - POS_W'(1));
  assign emit_rj  = !info.tdm && info.right_just && boundary;
  assign emit     = tick && synced && !cfg_chg && (emit_tdm || emit_lj || emit_rj);

  // right-justified words end before the boundary bit; all others include the current bit
  assign src  = emit_rj ? sreg : sreg_nxt;
  assign used = info.tdm ? WL_W'(SAMPLE_W) : wl;

  always_comb begin
    for (int i = 0; i < SAMPLE_W; i++)
      word[i] = (i < int'(used)) ? src[i] : src[used - WL_W'(1)];
  end

  always_comb begin
    if (info.tdm)
      chan = CH_W'(slot) + ((half_cur && !info.pulse) ? CH_W'(lim) : CH_W'(0));
    else if (info.right_just)
      chan = CH_W'(half_prev);
    else
      chan = CH_W'(half_cur);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg      <= '0;
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_data  <= '0;
    end else begin
      if (tick) sreg <= sreg_nxt;
      out_valid <= emit;
      if (emit) begin
        out_chan <= chan;
        out_data <= word;
      end
    end
  end
endmodule

// File: rtl/sai_rx.sv
module sai_rx
  import sai_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SLOT_BITS   = 32,
  parameter int MAX_CH      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = $clog2(MAX_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk,
  input  logic                fclk,
  input  logic                sdata,
  input  logic [2:0]          cfg_mode,
  input  logic                cfg_bclk_edge,
  input  logic                cfg_fclk_pol,
  input  logic [1:0]          cfg_wlen,
  output logic                out_valid,
  output logic [CH_W-1:0]     out_chan,
  output logic [SAMPLE_W-1:0] out_data
);
  localparam int POS_W = $clog2(MAX_CH * SLOT_BITS) + 1;

  fmt_info_t        info;
  logic [6:0]       cfg_now, cfg_q;
  logic             cfg_chg, tick, f_s, d_s;
  logic             boundary, half_cur, half_prev, synced;
  logic [POS_W-1:0] pos_cur;

  assign info    = fmt_decode(cfg_mode);
  assign cfg_now = {cfg_mode, cfg_bclk_edge, cfg_fclk_pol, cfg_wlen};
  assign cfg_chg = cfg_now != cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_now;
  end

  sai_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fclk(fclk), .sdata(sdata),
    .sample_lvl(~cfg_bclk_edge), .tick(tick), .f_s(f_s), .d_s(d_s)
  );

  sai_rx_framer #(.POS_W(POS_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .f_s(f_s), .start_lvl(cfg_fclk_pol),
    .pulse(info.pulse), .cfg_chg(cfg_chg), .boundary(boundary), .pos_cur(pos_cur),
    .half_cur(half_cur), .half_prev(half_prev), .synced(synced)
  );

  sai_rx_assemble #(
    .SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS), .MAX_CH(MAX_CH),
    .POS_W(POS_W), .CH_W(CH_W)
  ) u_asm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .d_s(d_s), .info(info), .wlen(cfg_wlen),
    .boundary(boundary), .pos_cur(pos_cur), .half_cur(half_cur), .half_prev(half_prev),
    .synced(synced), .cfg_chg(cfg_chg), .out_valid(out_valid), .out_chan(out_chan),
    .out_data(out_data)
  );
endmodule

// File: rtl/sai_rx_chk.sv
module sai_rx_chk #(
  parameter int SAMPLE_W = 24,
  parameter int CH_W     = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          cfg_mode,
  input logic                cfg_bclk_edge,
  input logic                cfg_fclk_pol,
  input logic [1:0]          cfg_wlen,
  input logic                out_valid,
  input logic [CH_W-1:0]     out_chan,
  input logic [SAMPLE_W-1:0] out_data
);
  logic [6:0] cfg_all;
  logic       stereo, tdm8;
  assign cfg_all = {cfg_mode, cfg_bclk_edge, cfg_fclk_pol, cfg_wlen};
  assign stereo  = (cfg_mode <= 3'd2) || (cfg_mode == 3'd7);
  assign tdm8    = (cfg_mode == 3'd3) || (cfg_mode == 3'd5);

  p_single_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_hold_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_data) && $stable(out_chan)));

  p_quiet_on_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_all) |=> !out_valid);

  p_stereo_chan_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $stable(cfg_all) && stereo) |-> (out_chan < CH_W'(2)));

  p_tdm8_chan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $stable(cfg_all) && tdm8) |-> (out_chan < CH_W'(8)));

  p_sign_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $stable(cfg_all) && stereo && cfg_wlen == 2'd0) |->
      ($countones(out_data[SAMPLE_W-1:SAMPLE_W-9]) == 0 ||
       $countones(out_data[SAMPLE_W-1:SAMPLE_W-9]) == 9));
endmodule

bind sai_rx sai_rx_chk #(.SAMPLE_W(SAMPLE_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_bclk_edge(cfg_bclk_edge),
  .cfg_fclk_pol(cfg_fclk_pol), .cfg_wlen(cfg_wlen), .out_valid(out_valid),
  .out_chan(out_chan), .out_data(out_data)
);

// File: tb/sim_sai_rx.sv
`timescale 1ns/1ps
module sim_sai_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic bclk = 1'b0, fclk = 1'b0, sdata = 1'b0;
  logic [2:0] cfg_mode = 3'd0;
  logic cfg_bclk_edge = 1'b0, cfg_fclk_pol = 1'b0;
  logic [1:0] cfg_wlen = 2'd2;
  logic out_valid;
  logic [3:0] out_chan;
  logic [23:0] out_data;

  sai_rx u0 (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fclk(fclk), .sdata(sdata),
    .cfg_mode(cfg_mode), .cfg_bclk_edge(cfg_bclk_edge), .cfg_fclk_pol(cfg_fclk_pol),
    .cfg_wlen(cfg_wlen), .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data)
  );

  int total = 0, bad = 0, vcount = 0;
  logic bq_f[$], bq_d[$];
  logic [27:0] exp_q[$];
  string cur_tag = "R9";
  logic [31:0] rs = 32'h1234_5678;
  logic prev_v = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [27:0] act, input logic [27:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [23:0] rnd24();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs[23:0];
  endfunction

  function automatic logic [23:0] sx(input logic [23:0] w, input int wl);
    logic [23:0] r;
    for (int i = 0; i < 24; i++) r[i] = (i < wl) ? w[i] : w[wl-1];
    return r;
  endfunction

  task automatic put(input logic f, input logic d);
    bq_f.push_back(f);
    bq_d.push_back(d);
  endtask

  // fmt: 0 delayed MSB, 1 MSB at boundary, 2 LSB before boundary
  task automatic build_stereo(input int fmt, input bit fp, input int wl, input int hb, input int frames);
    for (int p = 0; p < hb; p++) put(~fp, 1'b1);
    for (int fr = 0; fr < frames; fr++) begin
      for (int h = 0; h < 2; h++) begin
        logic [23:0] w;
        logic lvl;
        w = rnd24();
        lvl = (h == 0) ? fp : ~fp;
        for (int p = 0; p < hb; p++) begin
          logic b;
          b = 1'b1;
          if (fmt == 0 && p >= 1 && p <= wl) b = w[wl-p];
          if (fmt == 1 && p < wl)            b = w[wl-1-p];
          if (fmt == 2 && p >= hb - wl)      b = w[hb-1-p];
          put(lvl, b);
        end
        exp_q.push_back({4'(h), sx(w, wl)});
      end
    end
    for (int p = 0; p < 4; p++) put(fp, 1'b0);
  endtask

  task automatic build_tdm(input int n, input bit pulse, input bit fp, input int frames);
    for (int p = 0; p < 32; p++) put(~fp, 1'b1);
    for (int fr = 0; fr < frames; fr++) begin
      logic [23:0] w[16];
      for (int c = 0; c < n; c++) begin
        w[c] = rnd24();
        exp_q.push_back({4'(c), w[c]});
      end
      if (!pulse) begin
        for (int h = 0; h < 2; h++)
          for (int q = 0; q < n * 16; q++) begin
            logic b;
            b = 1'b1;
            if (q > 0 && ((q - 1) % 32) < 24) b = w[h*(n/2) + (q-1)/32][23 - ((q-1) % 32)];
            put((h == 0) ? fp : ~fp, b);
          end
      end else begin
        for (int q = 0; q < n * 32; q++) begin
          logic b;
          b = 1'b1;
          if (q > 0 && ((q - 1) % 32) < 24) b = w[(q-1)/32][23 - ((q-1) % 32)];
          put((q == 0) ? fp : ~fp, b);
        end
      end
    end
    for (int p = 0; p < 4; p++) put(fp, 1'b0);
  endtask

  task automatic drive();
    while (bq_f.size() > 0) begin
      logic f, d;
      f = bq_f.pop_front();
      d = bq_d.pop_front();
      @(negedge clk);
      bclk = cfg_bclk_edge;
      fclk = f;
      sdata = d;
      repeat (3) @(negedge clk);
      @(negedge clk);
      bclk = ~cfg_bclk_edge;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic set_cfg(input string tag, input int m, input bit be, input bit fp, input int wlf);
    @(negedge clk);
    cur_tag = tag;
    cfg_mode = 3'(m);
    cfg_bclk_edge = be;
    cfg_fclk_pol = fp;
    cfg_wlen = 2'(wlf);
    repeat (4) @(negedge clk);
  endtask

  task automatic end_test();
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, cur_tag, "all words delivered", 28'(exp_q.size()), 28'd0);
    exp_q.delete();
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        vcount++;
        if (prev_v) chk(1'b0, "R9", "strobe longer than one cycle", 28'd2, 28'd1);
        if (exp_q.size() == 0)
          chk(1'b0, "R10", {"unexpected word in ", cur_tag}, {out_chan, out_data}, 28'd0);
        else begin
          logic [27:0] ev;
          ev = exp_q.pop_front();
          chk({out_chan, out_data} == ev, cur_tag, "word", {out_chan, out_data}, ev);
        end
      end
      prev_v = out_valid;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v0;
    repeat (10) @(negedge clk);
    chk(out_valid == 1'b0 && out_chan == 4'd0 && out_data == 24'd0, "R9", "reset state",
        {out_chan, out_data}, 28'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    set_cfg("R1 R6", 0, 1'b0, 1'b0, 2);  build_stereo(0, 1'b0, 24, 32, 3); drive(); end_test();
    set_cfg("R1 R4", 0, 1'b0, 1'b0, 0);  build_stereo(0, 1'b0, 16, 32, 3); drive(); end_test();
    set_cfg("R2 R5 R6", 1, 1'b1, 1'b1, 1); build_stereo(1, 1'b1, 20, 24, 3); drive(); end_test();
    set_cfg("R3 R4", 2, 1'b0, 1'b1, 0);  build_stereo(2, 1'b1, 16, 32, 3); drive(); end_test();
    set_cfg("R3 R5", 2, 1'b1, 1'b1, 3);  build_stereo(2, 1'b1, 24, 32, 2); drive(); end_test();
    set_cfg("R7", 3, 1'b0, 1'b0, 2);     build_tdm(8, 1'b0, 1'b0, 2);      drive(); end_test();
    set_cfg("R7 R5", 4, 1'b1, 1'b1, 2);  build_tdm(16, 1'b0, 1'b1, 2);     drive(); end_test();
    set_cfg("R8", 5, 1'b0, 1'b1, 2);     build_tdm(8, 1'b1, 1'b1, 2);      drive(); end_test();
    set_cfg("R8", 6, 1'b0, 1'b1, 2);     build_tdm(16, 1'b1, 1'b1, 2);     drive(); end_test();

    // R10: format change, then toggles up to and including the first opening edge only
    set_cfg("R10", 2, 1'b0, 1'b1, 2);
    v0 = vcount;
    for (int p = 0; p < 32; p++) put(1'b0, 1'b1);
    for (int p = 0; p < 32; p++) put(1'b1, 1'b1);
    drive();
    end_test();
    chk(vcount == v0, "R10", "no word before first frame start", 28'(vcount - v0), 28'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule